// File: doc/BRIEF.md
# Carry-Inclusive Word Shifter

This block shifts a 17-bit word made of a 16-bit accumulator and a carry bit held as the most significant bit. The carry always takes part in the shift, and bit 16 of the result becomes the new carry. One request gives a 5-bit count (0 to 31), a direction and a mode. The mode is either a circular rotation of all 17 bits or an end-off shift that fills the vacated positions with zeros.

The datapath only shifts left. A right shift reuses it: the control inverts the count bits and picks a different fill pattern to place beside the operand. The shift is combinational within one clock. The result is captured into the output register on the edge where the request is presented and held until the next request.

Top module: `carry_ring_shifter`

## Requirements
- R1: While reset is asserted, `resValid` is 0 and `resAcc` and `resCarry` are 0.
- R2: `resValid` equals the value `reqValid` had at the previous rising clock edge.
- R3: With a count of 0 the result equals the operand, in every direction and mode.
- R4: A circular left shift (`reqRight`=0, `reqEndOff`=0) by n moves operand bit k to result bit (k+n) mod 17, counting the carry as bit 16.
- R5: A circular right shift (`reqRight`=1, `reqEndOff`=0) by n moves operand bit k to result bit (k-n) mod 17.
- R6: An end-off left shift (`reqEndOff`=1) by n moves bit k to bit k+n when k+n is at most 16, drops the rest and fills result bits below n with 0.
- R7: An end-off right shift by n moves bit k to bit k-n when k is at least n and fills the top n positions, including the carry, with 0.
- R8: An end-off shift by more than 16 in either direction gives an all-zero 17-bit result.
- R9: A circular shift by 17 in either direction returns the operand unchanged.
- R10: When `reqValid` is 0 at a clock edge, `resAcc` and `resCarry` keep their values.
- R11: A circular shift keeps the number of 1 bits in the 17-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present; the result is captured on this edge |
| reqAcc | input | 16 | Accumulator part of the operand |
| reqCarry | input | 1 | Carry bit, operand bit 16 |
| reqCount | input | 5 | Shift count, 0 to 31 |
| reqRight | input | 1 | 1 selects a right shift, 0 a left shift |
| reqEndOff | input | 1 | 1 selects end-off with zero fill, 0 selects circular |
| resValid | output | 1 | Result register was loaded on the last edge |
| resAcc | output | 16 | Accumulator part of the result |
| resCarry | output | 1 | New carry, result bit 16 |

## Verification
The properties assume that every request input is a defined level at each clock edge after reset, and that the request was sampled one edge before the result it constrains. The checker compares the registered result against the previous cycle's operand and count only. The bench changes inputs only on falling edges and holds `reqValid` low during reset, so every property sees stable inputs on the edge that loads the result. The random sweep covers every count, both directions and both modes. Idle cycles with changed operands check that the held result stays put.

// File: rtl/shift_pkg.sv
package shift_pkg;
  // Strobes from the control to the datapath for one request.
  typedef struct packed {
    logic capture;   // load the result register on this edge
    logic useRight;  // place the fill pattern above the operand
    logic zeroFill;  // end-off mode: fill pattern is all zeros
  } ctlStrobes_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             reqRight,
  input  logic             reqEndOff,
  output ctlStrobes_t      strobes,
  output logic [CNT_W-1:0] amount,
  output logic             resValid
);
  // The datapath only shifts left. A right shift of n becomes a left
  // shift of (2**CNT_W - 1 - n) on a word whose fill sits above the operand.
  always_comb begin
    strobes.capture  = reqValid;
    strobes.useRight = reqRight;
    strobes.zeroFill = reqEndOff;
    amount           = reqRight ? ~reqCount : reqCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= reqValid;
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [CNT_W-1:0] amount,
  input  logic [ACC_W-1:0] reqAcc,
  input  logic             reqCarry,
  output logic [ACC_W-1:0] resAcc,
  output logic             resCarry
);
  localparam int WORD_W = ACC_W + 1;
  localparam int MAX_SH = (1 << CNT_W) - 1;
  localparam int EXT_W  = WORD_W + MAX_SH;
  localparam int LEFT_OFS = WORD_W - (MAX_SH % WORD_W);

  logic [WORD_W-1:0] word;
  logic [MAX_SH-1:0] fillLeft;
  logic [MAX_SH-1:0] fillRight;
  logic [EXT_W-1:0]  extWord;
  logic [EXT_W-1:0]  stage [CNT_W+1];
  logic [WORD_W-1:0] shifted;

  assign word = {reqCarry, reqAcc};

  // Fill patterns: the bits that enter the result window from outside the
  // operand. In circular mode they repeat the operand modulo WORD_W.
  for (genvar j = 0; j < MAX_SH; j++) begin : g_fill
    assign fillLeft[j]  = strobes.zeroFill ? 1'b0 : word[(j + LEFT_OFS) % WORD_W];
    assign fillRight[j] = strobes.zeroFill ? 1'b0 : word[j % WORD_W];
  end

  assign extWord = strobes.useRight ? {fillRight, word} : {word, fillLeft};

  // Logarithmic left shifter, one stage per count bit.
  assign stage[0] = extWord;
  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    assign stage[s+1] = amount[s] ? (stage[s] << (1 << s)) : stage[s];
  end

  assign shifted = stage[CNT_W][EXT_W-1:MAX_SH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resAcc   <= '0;
      resCarry <= 1'b0;
    end else if (strobes.capture) begin
      resAcc   <= shifted[ACC_W-1:0];
      resCarry <= shifted[ACC_W];
    end
  end
endmodule

// File: rtl/carry_ring_shifter.sv
module carry_ring_shifter
  import shift_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [ACC_W-1:0] reqAcc,
  input  logic             reqCarry,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             reqRight,
  input  logic             reqEndOff,
  output logic             resValid,
  output logic [ACC_W-1:0] resAcc,
  output logic             resCarry
);
  ctlStrobes_t      strobes;
  logic [CNT_W-1:0] amount;

  shift_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCount(reqCount),
    .reqRight(reqRight), .reqEndOff(reqEndOff), .strobes(strobes),
    .amount(amount), .resValid(resValid)
  );

  shift_datapath #(.ACC_W(ACC_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .amount(amount),
    .reqAcc(reqAcc), .reqCarry(reqCarry), .resAcc(resAcc), .resCarry(resCarry)
  );
endmodule

// File: rtl/shift_checker.sv
module shift_checker #(
  parameter int ACC_W = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [ACC_W-1:0] reqAcc,
  input logic             reqCarry,
  input logic [CNT_W-1:0] reqCount,
  input logic             reqRight,
  input logic             reqEndOff,
  input logic             resValid,
  input logic [ACC_W-1:0] resAcc,
  input logic             resCarry
);
  localparam int WORD_W = ACC_W + 1;
  logic [WORD_W-1:0] inWord;
  logic [WORD_W-1:0] outWord;
  assign inWord  = {reqCarry, reqAcc};
  assign outWord = {resCarry, resAcc};

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    resValid == $past(reqValid));

  assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid) && ($past(reqCount) == '0) |-> outWord == $past(inWord));

  assert_endoff_big_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid) && $past(reqEndOff) && ($past(reqCount) > CNT_W'(ACC_W))
      |-> outWord == '0);

  assert_rotate_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid) && !$past(reqEndOff) && ($past(reqCount) == CNT_W'(WORD_W))
      |-> outWord == $past(inWord));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqValid) |-> $stable(outWord));

  assert_ones_kept_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid) && !$past(reqEndOff)
      |-> $countones(outWord) == $countones($past(inWord)));
endmodule

bind carry_ring_shifter shift_checker #(.ACC_W(ACC_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAcc(reqAcc),
  .reqCarry(reqCarry), .reqCount(reqCount), .reqRight(reqRight),
  .reqEndOff(reqEndOff), .resValid(resValid), .resAcc(resAcc),
  .resCarry(resCarry)
);

// File: tb/carry_ring_shifter_tb_top.sv
module carry_ring_shifter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAcc = '0;
  logic        reqCarry = 1'b0;
  logic [4:0]  reqCount = '0;
  logic        reqRight = 1'b0;
  logic        reqEndOff = 1'b0;
  logic        resValid;
  logic [15:0] resAcc;
  logic        resCarry;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  carry_ring_shifter dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAcc(reqAcc),
    .reqCarry(reqCarry), .reqCount(reqCount), .reqRight(reqRight),
    .reqEndOff(reqEndOff), .resValid(resValid), .resAcc(resAcc),
    .resCarry(resCarry)
  );

  // Bit-by-bit model built from the requirement text.
  function automatic logic [16:0] model(input logic [16:0] w, input int n,
                                        input bit right, input bit endOff);
    logic [16:0] r = '0;
    for (int i = 0; i < 17; i++) begin
      int src = right ? i + n : i - n;
      if (src >= 0 && src < 17) r[i] = w[src];
      else if (!endOff) r[i] = w[((src % 17) + 17) % 17];
      else r[i] = 1'b0;
    end
    return r;
  endfunction

  function automatic string tagFor(input int n, input bit right, input bit endOff);
    if (n == 0) return "R3";
    if (endOff && n > 16) return "R8";
    if (!endOff && n == 17) return "R9";
    if (!endOff) return right ? "R5" : "R4";
    return right ? "R7" : "R6";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runOne(input logic [16:0] w, input int n, input bit right, input bit endOff);
    logic [16:0] exp;
    @(negedge clk);
    reqValid = 1'b1; {reqCarry, reqAcc} = w; reqCount = 5'(n);
    reqRight = right; reqEndOff = endOff;
    exp = model(w, n, right, endOff);
    @(negedge clk);
    check(tagFor(n, right, endOff), {15'd0, resCarry, resAcc}, {15'd0, exp});
    check("R2", {31'd0, resValid}, 32'd1);
    if (!endOff) check("R11", $countones({resCarry, resAcc}), $countones(w));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [16:0] held;
    void'($urandom(32'd2024));
    #7;
    // R1 reset state
    check("R1", {15'd0, resValid, resCarry}, 32'd0);
    check("R1", {16'd0, resAcc}, 32'd0);
    rstN = 1'b1;

    // Directed corners
    runOne(17'h10000, 1, 1'b0, 1'b0);   // carry wraps into bit 0
    runOne(17'h00001, 1, 1'b1, 1'b0);   // bit 0 wraps into carry
    runOne(17'h1FFFF, 1, 1'b1, 1'b1);   // carry vacated, zero filled
    runOne(17'h1FFFF, 16, 1'b0, 1'b1);
    runOne(17'h1FFFF, 17, 1'b0, 1'b1);
    runOne(17'h1FFFF, 31, 1'b1, 1'b1);
    runOne(17'h0A5C3, 17, 1'b1, 1'b0);
    runOne(17'h15A3C, 0, 1'b1, 1'b1);

    // Sweep: every count, direction and mode on random operands
    for (int n = 0; n < 32; n++)
      for (int d = 0; d < 2; d++)
        for (int m = 0; m < 2; m++)
          for (int k = 0; k < 3; k++)
            runOne(17'($urandom()), n, d[0], m[0]);

    // R10: idle cycle with new operand leaves the result unchanged
    runOne(17'h12345, 3, 1'b0, 1'b0);
    held = model(17'h12345, 3, 1'b0, 1'b0);
    @(negedge clk);
    reqValid = 1'b0; {reqCarry, reqAcc} = 17'h0FFFF; reqCount = 5'd7;
    @(negedge clk);
    check("R10", {15'd0, resCarry, resAcc}, {15'd0, held});
    check("R2", {31'd0, resValid}, 32'd0);
    @(negedge clk);
    check("R10", {15'd0, resCarry, resAcc}, {15'd0, held});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule